// File: doc/BRIEF.md
# Edge-Interval Capture Timer

This block measures how long a digital input stays between edges, for example the length of carrier bursts or of the gaps between them in a demodulated infrared stream. The input is first cleaned by a glitch filter that is clocked by a tick. A programmable edge sense then decides which filtered transitions count. A down counter measures the intervals in ticks.

After the block is enabled, the counter sits at all-ones until the first qualifying edge arrives, and then it starts counting down once per tick. Each later qualifying edge copies the running count into a capture register and restarts the counter from all-ones. The interval in ticks is therefore all-ones minus the captured value. An optional mode ignores edges after the first one, so that a single long interval can be timed to terminal count. When the counter reaches zero it raises a sticky timeout flag, reloads all-ones and waits for a new first edge.

Capture and timeout each drive a single-cycle interrupt pulse behind its own mask. A sticky flag records every filtered rising edge. The input must be synchronous to `clk`.

Top module: `edge_gap_timer`

## Requirements
- R1: The filtered level takes a new input value only after that value has been sampled on 2 consecutive ticks. A pulse that is seen on only one tick produces no edge and leaves the counter and the rising-edge flag untouched.
- R2: `edge_sel` chooses which edges qualify: 2'b01 means rising only, 2'b10 means falling only, 2'b11 means both, and 2'b00 means none. A non-qualifying edge neither starts the counter nor captures.
- R3: While `enable` is low, `count` is all-ones and edges are ignored. Once enabled, `count` stays at all-ones until the first qualifying edge.
- R4: The first qualifying edge starts the run. After that, every tick decrements `count` by one.
- R5: A later qualifying edge during a run loads the current count into the capture register and restarts the count from all-ones. The captured value equals all-ones minus the number of ticks between the two edges. High and low parts `{cap_hi,cap_lo}` change in the same cycle.
- R6: When `ignore_later` is high, edges after the start of a run are not acted on: nothing is captured and the counter keeps decrementing.
- R7: The tick that takes `count` from 1 to 0 sets `tmo_flag`, reloads all-ones and returns the counter to waiting for a first edge. An edge in that same cycle captures instead, with value 1.
- R8: `rise_flag` is set by every filtered rising edge, whatever the values of `edge_sel` and `enable`. A `status_clr` pulse clears `rise_flag` and `tmo_flag`. If a set and a clear happen in the same cycle, the set wins.
- R9: `cap_irq` (or `tmo_irq`) pulses for one cycle, in the cycle in which the new capture (or the timeout) becomes visible, but only if `cap_irq_en` (or `tmo_irq_en`) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable for the filter and the counter |
| sig_in | input | 1 | Measured input, synchronous to clk |
| enable | input | 1 | Run enable |
| edge_sel | input | 2 | Edge sense (R2 encoding) |
| ignore_later | input | 1 | Ignore edges after the run has started |
| cap_irq_en | input | 1 | Capture interrupt mask |
| tmo_irq_en | input | 1 | Timeout interrupt mask |
| status_clr | input | 1 | Clears the sticky flags |
| count | output | CNT_W | Running count |
| cap_hi | output | CNT_W-8 | Upper part of the capture |
| cap_lo | output | 8 | Lower 8 bits of the capture |
| tmo_flag | output | 1 | Sticky timeout flag |
| rise_flag | output | 1 | Sticky filtered-rising-edge flag |
| cap_irq | output | 1 | Capture interrupt pulse |
| tmo_irq | output | 1 | Timeout interrupt pulse |

## Verification
When the tick is high every cycle, a change on `sig_in` reaches the counter at the third clock edge after it is driven: one edge for the filter sample, one for the filter decision and one for the counter update. The capture and `count` can therefore be read just after that edge, and the bench samples three edges after each toggle. With a slower tick, the filter delay grows to two ticks, so the bench spaces the toggles by whole tick periods and keeps their phase the same. This makes the expected capture all-ones minus the gap divided by the tick period. Interrupt pulses are counted at the falling clock edge, and the totals are compared with the number of captures and timeouts that the gap sweep predicts.

// File: rtl/egt_pkg.sv
package egt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } run_state_e;

  localparam logic [1:0] SEL_RISE = 2'b01;
  localparam logic [1:0] SEL_FALL = 2'b10;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/egt_filter.sv
module egt_filter #(
  parameter int STABLE_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic raw,
  output logic level
);
  localparam int RUN_W = $clog2(STABLE_TICKS + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(STABLE_TICKS);
  localparam logic [RUN_W-1:0] RUN_NEAR = RUN_W'(STABLE_TICKS - 1);

  logic             cand;
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cand  <= 1'b0;
      run   <= RUN_FULL;
      level <= 1'b0;
    end else if (tick) begin
      if (raw != cand) begin
        cand <= raw;
        run  <= RUN_W'(1);
      end else begin
        if (run != RUN_FULL) run <= run + 1'b1;
        if (run >= RUN_NEAR) level <= cand;
      end
    end
  end

  // R1: the filtered level moves only on a tick
  a_r1_level_only_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(level));
  // R1: a new level is always the value last sampled at the input
  a_r1_level_from_input: assert property (@(posedge clk) disable iff (rst)
    (level != $past(level)) |-> ($past(raw) == level));
endmodule

// File: rtl/egt_edge.sv
module egt_edge
  import egt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  level,
  output edge_t ev
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= level;
  end

  always_comb begin
    ev.rise = level & ~prev;
    ev.fall = ~level & prev;
  end
endmodule

// File: rtl/egt_counter.sv
module egt_counter
  import egt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             enable,
  input  logic             qual,
  input  logic             ignore_later,
  input  logic             cap_irq_en,
  input  logic             tmo_irq_en,
  input  logic             status_clr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap,
  output logic             tmo_flag,
  output logic             cap_irq,
  output logic             tmo_irq
);
  localparam logic [CNT_W-1:0] ONES = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  run_state_e state;
  logic       cap_fire;
  logic       tmo_fire;

  always_comb begin
    cap_fire = enable && (state == ST_RUN) && qual && !ignore_later;
    tmo_fire = enable && (state == ST_RUN) && !cap_fire && tick && (cnt == ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= ONES;
      cap   <= '0;
    end else if (!enable) begin
      state <= ST_IDLE;
      cnt   <= ONES;
    end else begin
      case (state)
        ST_IDLE: begin
          state <= ST_ARMED;
          cnt   <= ONES;
        end
        ST_ARMED: begin
          if (qual) state <= ST_RUN;
        end
        ST_RUN: begin
          if (cap_fire) begin
            cap <= cnt;
            cnt <= ONES;
          end else if (tmo_fire) begin
            cnt   <= ONES;
            state <= ST_ARMED;
          end else if (tick) begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_flag <= 1'b0;
      cap_irq  <= 1'b0;
      tmo_irq  <= 1'b0;
    end else begin
      cap_irq <= cap_fire && cap_irq_en;
      tmo_irq <= tmo_fire && tmo_irq_en;
      if (tmo_fire)        tmo_flag <= 1'b1;
      else if (status_clr) tmo_flag <= 1'b0;
    end
  end

  // R3: waiting for the first edge keeps the count full
  a_r3_armed_full: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED) |-> (cnt == ONES));
  // R3: disabling forces the count back to full
  a_r3_off_full: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (cnt == ONES));
  // R6: a run in ignore mode never changes the capture
  a_r6_ignore_keeps_cap: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_RUN) && ignore_later) |=> $stable(cap));
  // R7: the timeout interrupt only follows a count of one
  a_r7_tmo_from_one: assert property (@(posedge clk) disable iff (rst)
    tmo_irq |-> ($past(cnt) == ONE));
  // R9: a capture pulse only follows a running state
  a_r9_cap_irq_after_run: assert property (@(posedge clk) disable iff (rst)
    cap_irq |-> ($past(state) == ST_RUN));
endmodule

// File: rtl/edge_gap_timer.sv
module edge_gap_timer
  import egt_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int STABLE_TICKS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               sig_in,
  input  logic               enable,
  input  logic [1:0]         edge_sel,
  input  logic               ignore_later,
  input  logic               cap_irq_en,
  input  logic               tmo_irq_en,
  input  logic               status_clr,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W-9:0]   cap_hi,
  output logic [7:0]         cap_lo,
  output logic               tmo_flag,
  output logic               rise_flag,
  output logic               cap_irq,
  output logic               tmo_irq
);
  localparam int LO_W = 8;

  logic             level;
  edge_t            ev;
  logic             qual;
  logic [CNT_W-1:0] cap;

  egt_filter #(.STABLE_TICKS(STABLE_TICKS)) u_filt (
    .clk(clk), .rst(rst), .tick(tick), .raw(sig_in), .level(level)
  );

  egt_edge u_edge (
    .clk(clk), .rst(rst), .level(level), .ev(ev)
  );

  always_comb begin
    qual = ((edge_sel & SEL_RISE) != 2'b00 && ev.rise) ||
           ((edge_sel & SEL_FALL) != 2'b00 && ev.fall);
  end

  egt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .enable(enable), .qual(qual),
    .ignore_later(ignore_later), .cap_irq_en(cap_irq_en),
    .tmo_irq_en(tmo_irq_en), .status_clr(status_clr),
    .cnt(count), .cap(cap), .tmo_flag(tmo_flag),
    .cap_irq(cap_irq), .tmo_irq(tmo_irq)
  );

  always_ff @(posedge clk) begin
    if (rst)             rise_flag <= 1'b0;
    else if (ev.rise)    rise_flag <= 1'b1;
    else if (status_clr) rise_flag <= 1'b0;
  end

  assign cap_hi = cap[CNT_W-1:LO_W];
  assign cap_lo = cap[LO_W-1:0];

  // R8: every filtered rising edge leaves the flag set
  a_r8_rise_sets_flag: assert property (@(posedge clk) disable iff (rst)
    ev.rise |=> rise_flag);
endmodule

// File: tb/sim_edge_gap_timer.sv
module sim_edge_gap_timer;
  localparam int W    = 10;
  localparam int FULL = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic sig_in = 1'b0;
  logic enable = 1'b0;
  logic [1:0] edge_sel = 2'b11;
  logic ignore_later = 1'b0;
  logic cap_irq_en = 1'b0;
  logic tmo_irq_en = 1'b0;
  logic status_clr = 1'b0;
  logic [W-1:0] count;
  logic [W-9:0] cap_hi;
  logic [7:0]   cap_lo;
  logic tmo_flag, rise_flag, cap_irq, tmo_irq;

  int nchk = 0;
  int nbad = 0;
  int div = 1;
  int ph = 0;
  int ncap_irq = 0;
  int ntmo_irq = 0;

  always #4 clk = ~clk;

  edge_gap_timer #(.CNT_W(W), .STABLE_TICKS(2)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .sig_in(sig_in), .enable(enable),
    .edge_sel(edge_sel), .ignore_later(ignore_later), .cap_irq_en(cap_irq_en),
    .tmo_irq_en(tmo_irq_en), .status_clr(status_clr), .count(count),
    .cap_hi(cap_hi), .cap_lo(cap_lo), .tmo_flag(tmo_flag),
    .rise_flag(rise_flag), .cap_irq(cap_irq), .tmo_irq(tmo_irq)
  );

  always @(posedge clk) begin
    #1;
    ph = (ph >= div - 1) ? 0 : ph + 1;
    tick = (ph == 0);
  end

  always @(negedge clk) begin
    if (cap_irq) ncap_irq++;
    if (tmo_irq) ntmo_irq++;
  end

  function automatic int capv();
    return int'({cap_hi, cap_lo});
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic toggle();
    sig_in = ~sig_in;
  endtask

  task automatic start(input logic [1:0] sel, input logic ign);
    enable = 1'b0;
    sig_in = 1'b0;
    status_clr = 1'b1;
    step(12);
    status_clr = 1'b0;
    edge_sel = sel;
    ignore_later = ign;
    enable = 1'b1;
    step(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int base;
    int keep;
    step(4);
    rst = 1'b0;
    step(1);
    // reset state
    check("R3 reset count", int'(count), FULL);
    check("R5 reset capture", capv(), 0);
    check("R8 reset flags", int'({tmo_flag, rise_flag, cap_irq, tmo_irq}), 0);

    // R3: enabled, no edge
    start(2'b11, 1'b0);
    step(20);
    check("R3 armed holds full", int'(count), FULL);

    // R5/R9: sweep of gaps with both edges
    cap_irq_en = 1'b1;
    base = ncap_irq;
    toggle();
    step(3);
    for (int g = 4; g <= 60; g++) begin
      step(g - 3);
      toggle();
      step(3);
      check("R5 capture gap", capv(), FULL + 1 - g);
    end
    check("R5 restart full", int'(count), FULL);
    step(2);
    check("R9 capture irq count", ncap_irq - base, 57);

    // R2: rising only, irq masked
    cap_irq_en = 1'b0;
    start(2'b01, 1'b0);
    keep = capv();
    base = ncap_irq;
    toggle(); step(5);
    toggle(); step(3);
    check("R2 fall ignored cap", capv(), keep);
    check("R4 count runs", int'(count), FULL - 5);
    step(4);
    toggle(); step(3);
    check("R2 rise period", capv(), FULL + 1 - 12);
    check("R9 masked capture irq", ncap_irq - base, 0);

    // R2: falling only, R8 rise flag on non-qualifying edge
    start(2'b10, 1'b0);
    toggle(); step(5);
    check("R2 rise does not start", int'(count), FULL);
    check("R8 rise flag", int'(rise_flag), 1);
    toggle(); step(7);
    toggle(); step(5);
    toggle(); step(3);
    check("R2 fall period", capv(), FULL + 1 - 12);
    status_clr = 1'b1; step(1); status_clr = 1'b0;
    check("R8 clear rise flag", int'(rise_flag), 0);

    // R2: no edge selected
    start(2'b00, 1'b0);
    keep = capv();
    for (int k = 0; k < 4; k++) begin
      toggle(); step(8);
    end
    check("R2 none count", int'(count), FULL);
    check("R2 none capture", capv(), keep);

    // R1: single-tick glitch then a two-tick pulse
    start(2'b11, 1'b0);
    toggle(); step(1); toggle();
    step(10);
    check("R1 glitch no start", int'(count), FULL);
    check("R1 glitch no rise", int'(rise_flag), 0);
    toggle(); step(2); toggle();
    step(3);
    check("R1 two-tick pulse", capv(), FULL + 1 - 2);

    // R6: ignore later edges
    start(2'b11, 1'b1);
    keep = capv();
    base = ncap_irq;
    cap_irq_en = 1'b1;
    toggle(); step(10);
    toggle(); step(10);
    toggle(); step(3);
    check("R6 capture unchanged", capv(), keep);
    check("R6 keeps counting", int'(count), FULL - 20);
    check("R6 no capture irq", ncap_irq - base, 0);

    // R7: boundary at terminal count
    start(2'b11, 1'b0);
    tmo_irq_en = 1'b1;
    base = ntmo_irq;
    toggle(); step(FULL);
    toggle(); step(3);
    check("R7 edge wins at terminal", capv(), 1);
    check("R7 no timeout yet", int'(tmo_flag), 0);
    step(FULL + 1 - 3);
    toggle(); step(3);
    check("R7 timeout flag", int'(tmo_flag), 1);
    check("R7 no capture on timeout", capv(), 1);
    check("R7 restarted full", int'(count), FULL);
    check("R9 timeout irq", ntmo_irq - base, 1);
    status_clr = 1'b1; step(1); status_clr = 1'b0;
    check("R8 clear timeout flag", int'(tmo_flag), 0);
    tmo_irq_en = 1'b0;

    // R3: disabled ignores edges
    enable = 1'b0;
    keep = capv();
    step(2);
    toggle(); step(10); toggle(); step(10);
    check("R3 disabled capture", capv(), keep);
    check("R3 disabled count", int'(count), FULL);

    // R4: slower tick
    div = 4;
    start(2'b11, 1'b0);
    toggle(); step(12);
    step(40 - 12);
    toggle(); step(12);
    check("R4 tick/4 gap 40", capv(), FULL - 10);
    step(80 - 12);
    toggle(); step(12);
    check("R4 tick/4 gap 80", capv(), FULL - 20);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule